// File: doc/BRIEF.md
# Interrupt Controller Command and Initialization Unit

This block is the register-access front end of an eight-line interrupt controller, together with the priority core it drives. A host writes bytes at one of two addresses. Depending on the address, the data bits and the current initialization step, each write starts the setup sequence, supplies one of the later setup words, issues a mode command or an end-of-interrupt/rotation command, or loads the mask register. Byte reads return the pending register, the in-service register or the mask register. When a poll has been requested, a read instead returns the winning line and acknowledges it on the spot.

The priority core takes eight request lines. Each line is either edge-triggered or level-triggered, chosen per line by an input vector. The core masks the pending set, ranks the lines in a circular order that starts at a rotation offset, and raises an interrupt request only when the winner outranks everything in service. An acknowledge strobe moves the winner into service. The block presents the vector (the base vector with the line number in its low three bits) as a continuous output.

Top module: `pic_cmd_unit`

## Requirements
- R1: After a synchronous reset every register is zero: mask, pending, in-service, rotation offset, base vector, initialization step and all mode flags. The outputs then read int_req=0 and vec_out=0x07.
- R2: An edge-triggered line sets its pending bit on a 0-to-1 transition of its input, and that bit survives the input falling. A level-triggered line (trig_level bit = 1) has a pending bit equal to its input on each clock. An acknowledge does not clear a level-triggered pending bit.
- R3: The winner is the first unmasked pending line in the circular order that starts at the rotation offset. int_req is 1 only when the winner ranks strictly above every in-service line. When the special-nesting flag is set, in-service line 2 is left out of that comparison. vec_out equals base vector | winner, or base vector | 7 when there is no request.
- R4: ack_in while int_req=1 sets the winner's in-service bit and clears its edge-triggered pending bit. ack_in with no request changes nothing.
- R5: In auto-EOI mode an acknowledge leaves the in-service register unchanged. If rotate-on-auto-EOI is also set, the rotation offset becomes winner+1 (mod 8).
- R6: A write at addr=0 with wdata[4]=1 starts initialization. It clears the mask, the offset, the read-select, the last-level history and all edge-triggered pending bits, records wdata[0] as "fourth word expected", and enters step 1. When wdata[0]=0 it also clears auto-EOI and special nesting.
- R7: In step 1 an addr=1 write stores wdata & 0xF8 as the base vector and moves to step 2. In step 2 an addr=1 write goes to step 3 if a fourth word is expected, otherwise back to normal operation. Addr=1 writes during initialization leave the mask unchanged.
- R8: In step 3 an addr=1 write sets special nesting from wdata[4] and auto-EOI from wdata[1], then returns to normal operation.
- R9: In normal operation an addr=1 write loads the mask register. An addr=1 read (no poll pending) returns the mask register.
- R10: An addr=0 write with wdata[4]=0 and wdata[3]=1 is a mode command. wdata[2]=1 requests a poll. wdata[1]=1 sets the read-select to wdata[0]. An addr=0 read then returns the in-service register (select 1) or the pending register (select 0).
- R11: For an addr=0 write with wdata[4:3]=00, command code wdata[7:5]=1 clears the highest-ranked in-service bit. Code 5 does the same and also sets the offset to that line+1. Neither code has any effect when nothing is in service.
- R12: Code 3 clears in-service bit wdata[2:0]. Code 7 does the same and sets the offset to wdata[2:0]+1. Code 6 sets the offset to wdata[2:0]+1. Codes 0 and 4 clear or set rotate-on-auto-EOI. Code 2 has no effect.
- R13: While a poll is pending, a read at either address returns the winner line number, or 7 if there is none, in the low three bits, and clears that line's pending and in-service bits. The poll request ends after that one read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe (consumes a pending poll) |
| addr | input | 1 | Register address select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle rd_en is sampled |
| irq_in | input | 8 | Interrupt request lines |
| trig_level | input | 8 | Per-line trigger select, 1 = level-triggered |
| ack_in | input | 1 | Interrupt acknowledge strobe |
| int_req | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector for the current winner |

## Verification
Most faults in this unit corrupt hidden state (initialization step, offset, mode flags, history bits) rather than an output directly. The bench therefore keeps a behavioural model of every register and compares int_req, vec_out and rdata on every clock. A wrong offset or nesting flag appears as a different vec_out or int_req in the first cycle with two competing pending lines. A wrong step counter appears at the next addr=1 write, as a changed mask readback or base vector. A stale in-service bit appears through a mode-command readback or as a request that stays suppressed.

// File: rtl/pic_pkg.sv
package pic_pkg;

    localparam int NLINES = 8;
    localparam int LW     = $clog2(NLINES);
    localparam int DW     = 8;
    localparam logic [DW-1:0] BASE_KEEP = ~DW'(NLINES - 1);

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_BASE = 2'd1,
        ST_SKIP = 2'd2,
        ST_MODE = 2'd3
    } init_step_e;

    typedef struct packed {
        logic [DW-1:0] imr;
        logic [DW-1:0] base;
        logic          nest;
        logic          aeoi;
        logic          rsel;
        logic          poll;
    } cfg_t;

    typedef struct packed {
        logic          clr_en;
        logic [LW-1:0] clr_line;
        logic          off_en;
        logic [LW-1:0] off_val;
        logic          rot_en;
        logic          rot_val;
    } isr_op_t;

    // Rank of the best set bit in circular order from off; NLINES when empty.
    function automatic logic [LW:0] rank_of(input logic [NLINES-1:0] m,
                                            input logic [LW-1:0] off);
        logic [LW:0]   r;
        logic [LW-1:0] idx;
        r = (LW+1)'(NLINES);
        for (int k = NLINES - 1; k >= 0; k--) begin
            idx = LW'(k) + off;
            if (m[idx]) r = (LW+1)'(k);
        end
        return r;
    endfunction

    function automatic logic [NLINES-1:0] onehot(input logic [LW-1:0] line);
        return NLINES'(1) << line;
    endfunction

endpackage

// File: rtl/pic_init_seq.sv
module pic_init_seq
    import pic_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          addr,
    input  logic [DW-1:0] wdata,
    output cfg_t          cfg,
    output logic          init_pulse,
    output logic          cmd_strobe
);

    init_step_e step;
    logic       want_fourth;

    assign init_pulse = wr_en && !addr && wdata[4];
    assign cmd_strobe = wr_en && !addr && !wdata[4] && !wdata[3];

    always_ff @(posedge clk) begin
        if (rst) begin
            step        <= ST_RUN;
            want_fourth <= 1'b0;
            cfg         <= '0;
        end else begin
            if (rd_en) cfg.poll <= 1'b0;
            if (wr_en && !addr) begin
                if (wdata[4]) begin
                    want_fourth <= wdata[0];
                    cfg.imr     <= '0;
                    cfg.rsel    <= 1'b0;
                    if (!wdata[0]) begin
                        cfg.nest <= 1'b0;
                        cfg.aeoi <= 1'b0;
                    end
                    step <= ST_BASE;
                end else if (wdata[3]) begin
                    if (wdata[2]) cfg.poll <= 1'b1;
                    if (wdata[1]) cfg.rsel <= wdata[0];
                end
            end else if (wr_en && addr) begin
                unique case (step)
                    ST_RUN:  cfg.imr <= wdata;
                    ST_BASE: begin
                        cfg.base <= wdata & BASE_KEEP;
                        step     <= ST_SKIP;
                    end
                    ST_SKIP: step <= want_fourth ? ST_MODE : ST_RUN;
                    ST_MODE: begin
                        cfg.nest <= wdata[4];
                        cfg.aeoi <= wdata[1];
                        step     <= ST_RUN;
                    end
                    default: step <= ST_RUN;
                endcase
            end
        end
    end

    // R6: an initialization start empties the mask and enters step 1
    a_r6_init_enters_base: assert property (@(posedge clk) disable iff (rst)
        init_pulse |=> (cfg.imr == '0 && step == ST_BASE));

    // R13: a poll request lasts for exactly one read
    a_r13_poll_single_read: assert property (@(posedge clk) disable iff (rst)
        (rd_en && cfg.poll && !wr_en) |=> !cfg.poll);

    // R7: addr=1 writes during initialization leave the mask alone
    a_r7_mask_held_in_init: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr && step != ST_RUN) |=> $stable(cfg.imr));

endmodule

// File: rtl/pic_ocw_decode.sv
module pic_ocw_decode
    import pic_pkg::*;
(
    input  logic              cmd_strobe,
    input  logic [DW-1:0]     wdata,
    input  logic [NLINES-1:0] isr,
    input  logic [LW-1:0]     offset,
    output isr_op_t           op
);

    logic [LW:0]   top_rank;
    logic [LW-1:0] top_line;
    logic [LW-1:0] sel_line;

    assign top_rank = rank_of(isr, offset);
    assign top_line = top_rank[LW-1:0] + offset;
    assign sel_line = wdata[LW-1:0];

    always_comb begin
        op = '0;
        if (cmd_strobe) begin
            unique case (wdata[7:5])
                3'd0, 3'd4: begin
                    op.rot_en  = 1'b1;
                    op.rot_val = wdata[7];
                end
                3'd1, 3'd5: begin
                    if (top_rank != (LW+1)'(NLINES)) begin
                        op.clr_en   = 1'b1;
                        op.clr_line = top_line;
                        op.off_en   = wdata[7];
                        op.off_val  = top_line + 1'b1;
                    end
                end
                3'd3: begin
                    op.clr_en   = 1'b1;
                    op.clr_line = sel_line;
                end
                3'd6: begin
                    op.off_en  = 1'b1;
                    op.off_val = sel_line + 1'b1;
                end
                3'd7: begin
                    op.clr_en   = 1'b1;
                    op.clr_line = sel_line;
                    op.off_en   = 1'b1;
                    op.off_val  = sel_line + 1'b1;
                end
                default: op = '0;
            endcase
        end
    end

endmodule

// File: rtl/pic_prio_core.sv
module pic_prio_core
    import pic_pkg::*;
#(
    parameter int CASCADE_LINE = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NLINES-1:0] irq_in,
    input  logic [NLINES-1:0] trig_level,
    input  logic [NLINES-1:0] imr,
    input  logic              nest,
    input  logic              aeoi,
    input  logic              ack,
    input  logic              poll_take,
    input  logic              init_clr,
    input  isr_op_t           op,
    output logic [NLINES-1:0] irr,
    output logic [NLINES-1:0] isr,
    output logic [LW-1:0]     offset,
    output logic              win_valid,
    output logic [LW-1:0]     win_line
);

    logic [NLINES-1:0] last_lvl;
    logic              rot_aeoi;
    logic [NLINES-1:0] cur_mask;
    logic [LW:0]       pend_rank;
    logic [LW:0]       cur_rank;
    logic              ack_take;
    logic              poll_hit;
    logic [NLINES-1:0] win_hot;
    logic [NLINES-1:0] isr_set;
    logic [NLINES-1:0] isr_clr;
    logic [NLINES-1:0] irr_clr;
    logic [NLINES-1:0] edge_next;
    logic [NLINES-1:0] irr_next;
    logic [LW-1:0]     off_next;

    assign cur_mask  = nest ? (isr & ~onehot(LW'(CASCADE_LINE))) : isr;
    assign pend_rank = rank_of(irr & ~imr, offset);
    assign cur_rank  = rank_of(cur_mask, offset);
    assign win_valid = pend_rank < cur_rank;
    assign win_line  = pend_rank[LW-1:0] + offset;
    assign win_hot   = onehot(win_line);

    assign ack_take  = ack && win_valid;
    assign poll_hit  = poll_take && win_valid;
    assign isr_set   = (ack_take && !aeoi) ? win_hot : '0;
    assign isr_clr   = (op.clr_en ? onehot(op.clr_line) : '0) | (poll_hit ? win_hot : '0);
    assign irr_clr   = (ack_take || poll_hit) ? win_hot : '0;

    always_comb begin
        edge_next = init_clr ? '0 : ((irr & ~irr_clr) | (irq_in & ~last_lvl));
        irr_next  = (edge_next & ~trig_level) | (irq_in & trig_level);
        off_next  = offset;
        if (init_clr)
            off_next = '0;
        else if (op.off_en)
            off_next = op.off_val;
        else if (ack_take && aeoi && rot_aeoi)
            off_next = win_line + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irr      <= '0;
            isr      <= '0;
            last_lvl <= '0;
            offset   <= '0;
            rot_aeoi <= 1'b0;
        end else begin
            irr      <= irr_next;
            isr      <= (isr | isr_set) & ~isr_clr;
            last_lvl <= init_clr ? '0 : irq_in;
            offset   <= off_next;
            if (op.rot_en) rot_aeoi <= op.rot_val;
        end
    end

    // R3: a request always has an unmasked pending line behind it
    a_r3_req_has_pending: assert property (@(posedge clk) disable iff (rst)
        win_valid |-> ((irr & ~imr) != '0));

    // R4: a plain acknowledge puts the winner in service
    a_r4_ack_sets_service: assert property (@(posedge clk) disable iff (rst)
        (ack && win_valid && !aeoi && !op.clr_en && !poll_take) |=> isr[$past(win_line)]);

    // R5: auto-EOI acknowledges leave the in-service register untouched
    a_r5_aeoi_keeps_service: assert property (@(posedge clk) disable iff (rst)
        (ack && aeoi && !op.clr_en && !poll_take) |=> isr == $past(isr));

    // R12: a clear command removes the named in-service bit
    a_r12_clear_named_line: assert property (@(posedge clk) disable iff (rst)
        op.clr_en |=> !isr[$past(op.clr_line)]);

    // R4: an acknowledge changes at most one in-service bit
    a_r4_ack_single_bit: assert property (@(posedge clk) disable iff (rst)
        (ack && !op.clr_en && !poll_take) |=> $onehot0(isr ^ $past(isr)));

endmodule

// File: rtl/pic_cmd_unit.sv
module pic_cmd_unit
    import pic_pkg::*;
#(
    parameter int CASCADE_LINE = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic [NLINES-1:0] irq_in,
    input  logic [NLINES-1:0] trig_level,
    input  logic              ack_in,
    output logic              int_req,
    output logic [DW-1:0]     vec_out
);

    cfg_t              cfg;
    isr_op_t           op;
    logic              init_pulse;
    logic              cmd_strobe;
    logic [NLINES-1:0] irr;
    logic [NLINES-1:0] isr;
    logic [LW-1:0]     offset;
    logic              win_valid;
    logic [LW-1:0]     win_line;
    logic [LW-1:0]     code_line;

    pic_init_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .addr       (addr),
        .wdata      (wdata),
        .cfg        (cfg),
        .init_pulse (init_pulse),
        .cmd_strobe (cmd_strobe)
    );

    pic_ocw_decode u_dec (
        .cmd_strobe (cmd_strobe),
        .wdata      (wdata),
        .isr        (isr),
        .offset     (offset),
        .op         (op)
    );

    pic_prio_core #(.CASCADE_LINE(CASCADE_LINE)) u_core (
        .clk        (clk),
        .rst        (rst),
        .irq_in     (irq_in),
        .trig_level (trig_level),
        .imr        (cfg.imr),
        .nest       (cfg.nest),
        .aeoi       (cfg.aeoi),
        .ack        (ack_in),
        .poll_take  (rd_en && cfg.poll),
        .init_clr   (init_pulse),
        .op         (op),
        .irr        (irr),
        .isr        (isr),
        .offset     (offset),
        .win_valid  (win_valid),
        .win_line   (win_line)
    );

    assign code_line = win_valid ? win_line : LW'(NLINES - 1);
    assign int_req   = win_valid;
    assign vec_out   = cfg.base | DW'(code_line);

    always_comb begin
        if (cfg.poll)
            rdata = DW'(code_line);
        else if (!addr)
            rdata = cfg.rsel ? DW'(isr) : DW'(irr);
        else
            rdata = cfg.imr;
    end

    // R1: reset leaves no request and the default vector
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!int_req && vec_out == DW'(NLINES - 1)));

endmodule

// File: tb/tb_pic_cmd_unit.sv
module tb_pic_cmd_unit;

    localparam int CLK_NS = 20;

    logic       clk = 1'b0;
    logic       rst, wr_en, rd_en, addr, ack_in;
    logic [7:0] wdata, irq_in, trig_level;
    logic [7:0] rdata, vec_out;
    logic       int_req;

    pic_cmd_unit dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq_in(irq_in), .trig_level(trig_level),
        .ack_in(ack_in), .int_req(int_req), .vec_out(vec_out)
    );

    always #(CLK_NS / 2) clk = ~clk;

    int    total = 0;
    int    bad   = 0;
    bit    done  = 0;
    bit    m_ok  = 0;
    string cur_req = "R1";

    // behavioural model state
    logic [7:0] m_irr, m_isr, m_last, m_imr, m_base;
    int         m_off, m_step;
    bit         m_four, m_nest, m_aeoi, m_rot, m_rsel, m_poll;

    function automatic int m_first(input logic [7:0] m);
        for (int k = 0; k < 8; k++)
            if (m[(k + m_off) % 8]) return k;
        return 8;
    endfunction

    function automatic int m_win();
        logic [7:0] cur;
        int pk;
        pk  = m_first(m_irr & ~m_imr);
        cur = m_isr;
        if (m_nest) cur[2] = 1'b0;
        if (pk < m_first(cur)) return (pk + m_off) % 8;
        return -1;
    endfunction

    task automatic model_step();
        int w, ns, code, ln;
        if (rst) begin
            m_irr = 0; m_isr = 0; m_last = 0; m_imr = 0; m_base = 0;
            m_off = 0; m_step = 0; m_four = 0; m_nest = 0; m_aeoi = 0;
            m_rot = 0; m_rsel = 0; m_poll = 0; m_ok = 1;
            return;
        end
        w  = m_win();
        ns = m_first(m_isr);
        ns = (ns == 8) ? -1 : (ns + m_off) % 8;
        if (ack_in && w >= 0) begin
            if (!m_aeoi) m_isr[w] = 1'b1;
            else if (m_rot) m_off = (w + 1) % 8;
            m_irr[w] = 1'b0;
        end
        if (rd_en && m_poll) begin
            m_poll = 0;
            if (w >= 0) begin m_irr[w] = 1'b0; m_isr[w] = 1'b0; end
        end
        if (wr_en && !addr) begin
            if (wdata[4]) begin
                m_four = wdata[0]; m_imr = 0; m_off = 0; m_rsel = 0;
                if (!wdata[0]) begin m_nest = 0; m_aeoi = 0; end
                m_step = 1;
            end else if (wdata[3]) begin
                if (wdata[2]) m_poll = 1;
                if (wdata[1]) m_rsel = wdata[0];
            end else begin
                code = int'(wdata[7:5]);
                ln   = int'(wdata[2:0]);
                case (code)
                    0, 4: m_rot = (code == 4);
                    1, 5: if (ns >= 0) begin
                        m_isr[ns] = 1'b0;
                        if (code == 5) m_off = (ns + 1) % 8;
                    end
                    3: m_isr[ln] = 1'b0;
                    6: m_off = (ln + 1) % 8;
                    7: begin m_isr[ln] = 1'b0; m_off = (ln + 1) % 8; end
                    default: ;
                endcase
            end
        end else if (wr_en && addr) begin
            case (m_step)
                0: m_imr = wdata;
                1: begin m_base = wdata & 8'hF8; m_step = 2; end
                2: m_step = m_four ? 3 : 0;
                default: begin m_nest = wdata[4]; m_aeoi = wdata[1]; m_step = 0; end
            endcase
        end
        for (int i = 0; i < 8; i++) begin
            if (trig_level[i]) m_irr[i] = irq_in[i];
            else if (wr_en && !addr && wdata[4]) m_irr[i] = 1'b0;
            else if (irq_in[i] && !m_last[i]) m_irr[i] = 1'b1;
        end
        m_last = (wr_en && !addr && wdata[4]) ? 8'h00 : irq_in;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        int w, e_rd;
        if (!m_ok) return;
        w = m_win();
        if (m_poll) e_rd = (w >= 0) ? w : 7;
        else if (!addr) e_rd = m_rsel ? int'(m_isr) : int'(m_irr);
        else e_rd = int'(m_imr);
        chk(cur_req, "int_req", int'(int_req), (w >= 0) ? 1 : 0);
        chk(cur_req, "vec_out", int'(vec_out), int'(m_base) | ((w >= 0) ? w : 7));
        chk(cur_req, "rdata", int'(rdata), e_rd);
    endtask

    task automatic do_cycle();
        #2;
        compare_all();
        @(posedge clk);
        model_step();
        @(negedge clk);
        wr_en = 0; rd_en = 0; ack_in = 0;
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1;
        do_cycle();
    endtask

    task automatic rd(input logic a, input string req, input int exp);
        addr = a; rd_en = 1;
        #1;
        chk(req, "read", int'(rdata), exp);
        do_cycle();
    endtask

    task automatic ack();
        ack_in = 1;
        do_cycle();
    endtask

    task automatic lines(input logic [7:0] v);
        irq_in = v;
        do_cycle();
    endtask

    task automatic pulse(input logic [7:0] v);
        lines(v);
        lines(8'h00);
    endtask

    task automatic expect_out(input string req, input int e_int, input int e_vec);
        #1;
        chk(req, "int_req", int'(int_req), e_int);
        chk(req, "vec_out", int'(vec_out), e_vec);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired, actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1; wr_en = 0; rd_en = 0; addr = 0; ack_in = 0;
        wdata = 0; irq_in = 0; trig_level = 0;
        @(negedge clk);
        do_cycle();
        do_cycle();
        rst = 0;

        // R1: reset state
        cur_req = "R1";
        expect_out("R1", 0, 8'h07);
        rd(1, "R1", 0);

        // R6, R7, R8: full sequence with a fourth word
        cur_req = "R7";
        wr(0, 8'h11);
        wr(1, 8'h45);
        wr(1, 8'h00);
        wr(1, 8'h00);
        expect_out("R7", 0, 8'h47);

        // R9: mask write and readback
        cur_req = "R9";
        wr(1, 8'hF0);
        rd(1, "R9", 8'hF0);

        // R2, R3: edge requests and ranking
        cur_req = "R3";
        lines(8'h08);
        expect_out("R2", 1, 8'h43);
        lines(8'h0A);
        expect_out("R3", 1, 8'h41);
        lines(8'h00);
        expect_out("R2", 1, 8'h41);

        // R4: acknowledge, then lower line is blocked
        cur_req = "R4";
        ack();
        expect_out("R3", 0, 8'h47);

        // R10: read-select through a mode command
        cur_req = "R10";
        wr(0, 8'h0B);
        rd(0, "R10", 8'h02);
        wr(0, 8'h0A);
        rd(0, "R10", 8'h08);

        // R11: non-specific end of interrupt
        cur_req = "R11";
        wr(0, 8'h20);
        expect_out("R11", 1, 8'h43);

        // R12: specific clear, code 2 no effect
        cur_req = "R12";
        ack();
        wr(0, 8'h40);
        wr(0, 8'h0B);
        rd(0, "R12", 8'h08);
        wr(0, 8'h63);
        rd(0, "R12", 8'h00);

        // R11: code 5 rotates past the cleared line
        cur_req = "R11";
        wr(1, 8'h00);
        pulse(8'h20);
        ack();
        wr(0, 8'hA0);
        pulse(8'h44);
        expect_out("R11", 1, 8'h46);

        // R12: code 6 and code 7
        cur_req = "R12";
        wr(0, 8'hC1);
        expect_out("R12", 1, 8'h42);
        ack();
        wr(0, 8'hE2);
        expect_out("R12", 1, 8'h46);
        rd(0, "R12", 8'h00);

        // R13: poll read acknowledges in place, then none
        cur_req = "R13";
        wr(0, 8'h0C);
        rd(0, "R13", 8'h06);
        expect_out("R13", 0, 8'h47);
        wr(0, 8'h0C);
        rd(1, "R13", 8'h07);
        rd(1, "R13", 8'h00);

        // R2: level-triggered line survives acknowledge
        cur_req = "R2";
        trig_level = 8'h01;
        lines(8'h01);
        expect_out("R2", 1, 8'h40);
        ack();
        wr(0, 8'h0A);
        rd(0, "R2", 8'h01);
        lines(8'h00);
        rd(0, "R2", 8'h00);
        wr(0, 8'h20);
        trig_level = 8'h00;

        // R5, R8: auto-EOI with rotation
        cur_req = "R5";
        wr(0, 8'h11);
        wr(1, 8'h88);
        wr(1, 8'h00);
        wr(1, 8'h02);
        wr(0, 8'h80);
        pulse(8'h10);
        expect_out("R5", 1, 8'h8C);
        ack();
        wr(0, 8'h0B);
        rd(0, "R5", 8'h00);
        pulse(8'h50);
        expect_out("R5", 1, 8'h8E);

        // R6: start without a fourth word clears auto-EOI and edge pending
        cur_req = "R6";
        wr(0, 8'h10);
        expect_out("R6", 0, 8'h8F);
        wr(1, 8'h20);
        wr(1, 8'h00);
        wr(1, 8'h5A);
        rd(1, "R7", 8'h5A);
        wr(1, 8'h00);
        pulse(8'h01);
        ack();
        wr(0, 8'h0B);
        rd(0, "R6", 8'h01);
        wr(0, 8'h20);

        // R3, R8: special nesting lets the cascade line re-request
        cur_req = "R8";
        wr(0, 8'h11);
        wr(1, 8'h00);
        wr(1, 8'h00);
        wr(1, 8'h10);
        pulse(8'h04);
        ack();
        pulse(8'h04);
        expect_out("R3", 1, 8'h02);

        do_cycle();
        done = 1;
        summary();
        $finish;
    end

endmodule